// File: doc/BRIEF.md
# Indexed Register Bank with Mode-Gated Upper Space

This block is the host-facing register interface of a peripheral. A 2-bit address bus reaches four directly addressed 8-bit registers. Two of them form an index/data pair: the host loads an index into the pointer register, then reads or writes one of 32 indirect 8-bit control registers through the data register. The other two direct registers are a status register and a programmed-I/O data port. That port passes bytes between the host and the peripheral without going through the index mechanism.

After reset the block is in a legacy mode, and only indirect registers 0 to 15 can be reached. Setting one control bit inside indirect register 12 switches to extended mode and opens registers 16 to 31. Clearing that bit goes back to legacy mode. Three locations in the upper space are reserved. The contents of all 32 indirect registers are presented on a flat output bus for the peripheral logic that uses them. Reset is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `ixreg_bank`

## Requirements
- R1: After reset, the index pointer is 0, all 32 indirect registers are 0x00, the block is in legacy mode, and the programmed-I/O output is 0x00.
- R2: A write to direct address 0 loads host_wdata[4:0] into the index pointer. A read of direct address 0 returns the pointer in bits 4:0, with bits 7:5 reading as zero.
- R3: A write to direct address 1 stores host_wdata into the indirect register selected by the index. The change is visible on ctrl_regs (register n at bits 8n+7:8n) and on reads from the clock edge that samples the write strobe. A read of direct address 1 returns the selected register in the same cycle as host_rd.
- R4: In legacy mode, index bit 4 is ignored, so indices 16 to 31 alias onto registers 0 to 15, and registers 16 to 31 never change.
- R5: Bit 6 of indirect register 12 is the mode bit: 1 selects extended mode and 0 selects legacy mode. It can be written in either mode, and clearing it returns the block to legacy mode.
- R6: In extended mode, indices 16 to 31 address 16 distinct registers, separate from registers 0 to 15.
- R7: Indirect locations 22, 27 and 29 are reserved. They read as 0x00 and ignore writes.
- R8: A read of direct address 2 (status) returns the mode bit in bit 0 and zeros in bits 7:1. Writes to address 2 change nothing.
- R9: A write to direct address 3 loads pio_out on the sampling edge, and a read of address 3 returns pio_in. Neither access touches the index pointer or the indirect registers.
- R10: host_rdata is 0x00 in any cycle in which host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Direct register select |
| host_wr | input | 1 | Write strobe, sampled on the rising edge |
| host_rd | input | 1 | Read strobe, data returned in the same cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| pio_in | input | 8 | Byte offered by the peripheral to the host |
| pio_out | output | 8 | Byte last written by the host to the data port |
| ctrl_regs | output | 256 | Contents of the 32 indirect registers, register n at bits 8n+7:8n |

## Verification
The assertions assume that the host never raises host_rd and host_wr in the same cycle. They also assume that the strobes and the address are steady around the sampling edge. The bench drives every access for exactly one cycle, changing inputs only on the falling edge and raising a single strobe at a time. The stimulus sweeps all 32 index values in both modes. It uses write data with bit 6 clear while in legacy mode, so that the mode bit changes only when a test sets or clears it on purpose.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [1:0] {
    DIR_INDEX  = 2'd0,
    DIR_DATA   = 2'd1,
    DIR_STATUS = 2'd2,
    DIR_PIO    = 2'd3
  } dir_sel_e;

  // Locations of the indirect space that hold no storage.
  function automatic logic is_reserved(input int unsigned loc);
    return (loc == 22) || (loc == 27) || (loc == 29);
  endfunction

endpackage

// File: rtl/rb_index_ptr.sv
module rb_index_ptr #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] view
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load) idx_d = din[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx  = idx_q;
  assign view = {{(DATA_W-IDX_W){1'b0}}, idx_q};

  // R2: a load captures the low index bits of the write data
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> idx == $past(din[IDX_W-1:0]));

  // R2: without a load the pointer holds
  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(idx));

endmodule

// File: rtl/rb_decode.sv
module rb_decode
  import regbank_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int NREG  = 32
) (
  input  logic             ext_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic             data_wr,
  output logic [IDX_W-1:0] eff_idx,
  output logic             rsv_hit,
  output logic [NREG-1:0]  we
);

  // In legacy mode the top index bit is dropped.
  always_comb begin
    eff_idx = idx;
    if (!ext_mode) eff_idx[IDX_W-1] = 1'b0;
  end

  always_comb begin
    rsv_hit = is_reserved(int'(eff_idx));
  end

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = data_wr && !rsv_hit && (eff_idx == IDX_W'(g));
  end

endmodule

// File: rtl/rb_store.sv
module rb_store
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 32,
  parameter int IDX_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        we,
  input  logic [DATA_W-1:0]      din,
  input  logic [IDX_W-1:0]       sel,
  output logic [DATA_W-1:0]      dout,
  output logic [NREG*DATA_W-1:0] image
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_loc
    if (is_reserved(g)) begin : g_rsv
      assign regs[g] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q, d;
      always_comb begin
        d = q;
        if (we[g]) d = din;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign regs[g] = q;
    end
    assign image[g*DATA_W +: DATA_W] = regs[g];
  end

  assign dout = regs[sel];

  // R3: at most one location is written per cycle
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  // R3: a write lands in the selected location
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |=> dout == $past(din));

endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 5,
  parameter int MODE_REG = 12,
  parameter int MODE_BIT = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      host_addr,
  input  logic                            host_wr,
  input  logic                            host_rd,
  input  logic [DATA_W-1:0]               host_wdata,
  output logic [DATA_W-1:0]               host_rdata,
  input  logic [DATA_W-1:0]               pio_in,
  output logic [DATA_W-1:0]               pio_out,
  output logic [(1<<IDX_W)*DATA_W-1:0]    ctrl_regs
);

  localparam int NREG = 1 << IDX_W;
  localparam int HALF = NREG / 2;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Direct write decode.
  logic wr_index, wr_data, wr_pio;
  always_comb begin
    wr_index = host_wr && (dir_sel_e'(host_addr) == DIR_INDEX);
    wr_data  = host_wr && (dir_sel_e'(host_addr) == DIR_DATA);
    wr_pio   = host_wr && (dir_sel_e'(host_addr) == DIR_PIO);
  end

  logic [IDX_W-1:0]       idx, eff_idx;
  logic [DATA_W-1:0]      idx_view, bank_dout;
  logic                   rsv_hit, ext_mode;
  logic [NREG-1:0]        we;
  logic [NREG*DATA_W-1:0] image;

  rb_index_ptr #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_index (
    .clk  (clk),
    .rst_n(rst_ni),
    .load (wr_index),
    .din  (host_wdata),
    .idx  (idx),
    .view (idx_view)
  );

  rb_decode #(.IDX_W(IDX_W), .NREG(NREG)) u_decode (
    .ext_mode(ext_mode),
    .idx     (idx),
    .data_wr (wr_data),
    .eff_idx (eff_idx),
    .rsv_hit (rsv_hit),
    .we      (we)
  );

  rb_store #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_store (
    .clk  (clk),
    .rst_n(rst_ni),
    .we   (we),
    .din  (host_wdata),
    .sel  (eff_idx),
    .dout (bank_dout),
    .image(image)
  );

  assign ext_mode  = image[MODE_REG*DATA_W + MODE_BIT];
  assign ctrl_regs = image;

  // Programmed-I/O output register.
  logic [DATA_W-1:0] pio_q, pio_d;
  always_comb begin
    pio_d = pio_q;
    if (wr_pio) pio_d = host_wdata;
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pio_q <= '0;
    else         pio_q <= pio_d;
  end
  assign pio_out = pio_q;

  // Read path, same cycle as the strobe.
  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      unique case (dir_sel_e'(host_addr))
        DIR_INDEX:  host_rdata = idx_view;
        DIR_DATA:   host_rdata = rsv_hit ? '0 : bank_dout;
        DIR_STATUS: host_rdata = {{(DATA_W-1){1'b0}}, ext_mode};
        DIR_PIO:    host_rdata = pio_in;
        default:    host_rdata = '0;
      endcase
    end
  end

  // R10: no read strobe, no data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    !host_rd |-> host_rdata == '0);

  // R4: legacy mode leaves the upper half untouched
  a_r4_upper_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ext_mode && wr_data) |=> $stable(ctrl_regs[NREG*DATA_W-1:HALF*DATA_W]));

  // R8: status reflects the mode bit held in the bank
  a_r8_status_view: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_rd && host_addr == 2'd2) |->
      host_rdata == {{(DATA_W-1){1'b0}}, ctrl_regs[MODE_REG*DATA_W + MODE_BIT]});

  // R8: status writes change nothing
  a_r8_status_write_inert: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_wr && host_addr == 2'd2) |=> $stable(ctrl_regs) && $stable(idx) && $stable(pio_out));

  // R9: data port write is isolated from the indexed space
  a_r9_pio_isolated: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_wr && host_addr == 2'd3) |=>
      $stable(ctrl_regs) && $stable(idx) && pio_out == $past(host_wdata));

  // R7: reserved locations never hold a value
  a_r7_reserved_read: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_rd && host_addr == 2'd1 && ext_mode &&
     (idx == IDX_W'(22) || idx == IDX_W'(27) || idx == IDX_W'(29))) |-> host_rdata == '0);

endmodule

// File: tb/test_ixreg_bank.sv
module test_ixreg_bank;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   host_addr;
  logic         host_wr, host_rd;
  logic [7:0]   host_wdata, host_rdata, pio_in, pio_out;
  logic [255:0] ctrl_regs;

  int checks = 0;
  int errors = 0;

  logic [7:0] model [32];
  logic       mode_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  ixreg_bank i_ixreg_bank (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pio_in(pio_in), .pio_out(pio_out), .ctrl_regs(ctrl_regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1;
    chk(tag, {24'd0, host_rdata}, {24'd0, exp});
    host_rd = 1'b0;
  endtask

  function automatic logic rsv(input int i);
    return i == 22 || i == 27 || i == 29;
  endfunction

  task automatic chk_image(input string tag);
    for (int i = 0; i < 32; i++)
      chk(tag, {24'd0, ctrl_regs[i*8 +: 8]}, {24'd0, model[i]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wr = 0; host_rd = 0;
    host_wdata = '0; pio_in = '0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    mode_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_chk(2'd0, 8'h00, "R1 index");
    rd_chk(2'd2, 8'h00, "R1 status");
    chk("R1 pio_out", {24'd0, pio_out}, 32'd0);
    chk_image("R1 image");

    // R10 idle read data
    @(negedge clk); host_addr = 2'd3; pio_in = 8'h5A; #1;
    chk("R10 idle", {24'd0, host_rdata}, 32'd0);

    // R2 index width
    wr(2'd0, 8'hFF);
    rd_chk(2'd0, 8'h1F, "R2 index mask");
    wr(2'd0, 8'hE9);
    rd_chk(2'd0, 8'h09, "R2 index mask");

    // R3 R4 legacy sweep: all 32 indices alias onto 0..15
    for (int i = 0; i < 32; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + 5) & 8'hBF;
      wr(2'd0, 8'(i));
      wr(2'd1, d);
      model[i & 15] = d;
      chk("R3 write visible", {24'd0, ctrl_regs[(i & 15)*8 +: 8]}, {24'd0, d});
    end
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'(i));
      rd_chk(2'd1, model[i & 15], "R4 legacy alias read");
    end
    chk_image("R4 upper untouched");
    rd_chk(2'd2, 8'h00, "R5 still legacy");

    // R5 set mode bit
    wr(2'd0, 8'd12);
    wr(2'd1, 8'h40 | model[12]);
    model[12] = 8'h40 | model[12];
    mode_m = 1'b1;
    rd_chk(2'd2, 8'h01, "R5 R8 extended status");

    // R6 R7 extended sweep
    for (int i = 0; i < 32; i++) begin
      if (i != 12) begin
        logic [7:0] d;
        d = 8'(i * 53 + 17);
        wr(2'd0, 8'(i));
        wr(2'd1, d);
        if (!rsv(i)) model[i] = d;
      end
    end
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'(i));
      rd_chk(2'd1, model[i], rsv(i) ? "R7 reserved read" : "R6 extended read");
    end
    chk_image("R6 R7 image");

    // R8 status write ignored
    wr(2'd0, 8'd5);
    wr(2'd2, 8'hFF);
    rd_chk(2'd2, 8'h01, "R8 status write ignored");
    rd_chk(2'd0, 8'h05, "R8 index unchanged");
    chk_image("R8 image unchanged");

    // R9 data port
    for (int v = 0; v < 256; v += 51) begin
      wr(2'd3, 8'(v ^ 8'hA5));
      chk("R9 pio_out", {24'd0, pio_out}, {24'd0, 8'(v ^ 8'hA5)});
      pio_in = 8'(v + 3);
      rd_chk(2'd3, 8'(v + 3), "R9 pio_in read");
    end
    rd_chk(2'd0, 8'h05, "R9 index unchanged");
    chk_image("R9 image unchanged");

    // R5 clear mode bit, back to legacy aliasing
    wr(2'd0, 8'd12);
    wr(2'd1, 8'h00);
    model[12] = 8'h00;
    mode_m = 1'b0;
    rd_chk(2'd2, 8'h00, "R5 back to legacy");
    wr(2'd0, 8'd20);
    rd_chk(2'd1, model[4], "R5 R4 alias after clear");
    wr(2'd1, 8'h3C);
    model[4] = 8'h3C;
    chk_image("R4 alias write after clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule